// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This peripheral keeps wall-clock time and a calendar date in packed BCD and moves them forward by one second each time a prescaler on the fast system clock wraps. A compare stage checks every new second against a programmable alarm time and date. Two status flags, alarm and per-second tick, are gated by enable bits and combined into one level interrupt. Software reaches everything through a simple 32-bit register bus with word offsets.

After reset the block does not count. It starts only when a fixed 32-bit unlock word has been written to the init register. Until then, writes to the time, date, weekday and alarm registers are dropped. Seconds roll into minutes and hours on a 24-hour clock. Days roll over at each month's length, with February extended in years divisible by four. The year is a two-digit BCD offset from 2000, so the range is 2000 to 2099. A binary weekday counter steps once at every midnight.

Top module: `cal_rtc_top`

## Requirements
- R1: After reset the registers read as follows: time (0x0C) is 0, date (0x10) is 0x000101, weekday (0x18) is 0, interrupt enable (0x28) and status (0x2C) are 0, init bit 0 (0x00) is 0, clock-format bit 0 (0x14) is 1. The interrupt output is low.
- R2: Init bit 0 becomes 1 only after 0xA5EB1357 is written to offset 0x00, and it then stays 1. Any other value leaves it at 0. While it is 0, time does not advance and writes to 0x0C, 0x10, 0x18, 0x1C and 0x20 have no effect.
- R3: The time register holds BCD seconds in [7:0], minutes in [15:8] and hours in [23:16]. Time advances one second every TICKS_PER_SEC clocks. A write to the time, date or weekday register restarts the prescaler, so the first advance lands TICKS_PER_SEC cycles after the write edge.
- R4: Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry into the day.
- R5: The date register holds BCD day in [7:0], month 1..12 in [15:8] and year 00..99 in [23:16]. Days roll at 30 for months 4, 6, 9 and 11 and at 31 for the other months except February. December rolls to January of the next year, and year 99 rolls to 00.
- R6: February has 29 days when the year is divisible by 4 and 28 otherwise. Bit 0 of offset 0x24 reads 1 exactly in those years.
- R7: Weekday at 0x18 is binary in [2:0]. It steps by one at every midnight rollover and wraps from 6 to 0.
- R8: The alarm time (0x1C) and alarm date (0x20) use the same layouts as the time and date registers. Status bit 0 sets on the advance whose resulting time and date equal all six alarm fields, and at no other advance.
- R9: Status bit 1 sets on every one-second advance.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R11: The interrupt output is high exactly when some status bit is 1 and its enable bit in 0x28 is 1 (bit 0 for alarm, bit 1 for tick).
- R12: The clock format register at 0x14 always reads bit 0 as 1 (24-hour mode), and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the carry chain at its extremes:
- the last second of a century, which must return to 2000-01-01;
- the end of February in leap and non-leap years;
- the end of a 30-day month;
- the weekday wrap from 6 to 0.

A design with a wrong month table or leap test shows an impossible date such as February 30 or April 31. A missing year wrap shows an invalid BCD year.

Before unlock, the bench writes a wrong init word and a time value and waits several seconds. A block that ignored the unlock would show a moving or overwritten time.

The alarm is placed two seconds ahead. The flag must stay low for the first second and rise on the second, which catches a compare made against the old time instead of the new one.

A status clear is placed on the exact tick edge. A block that lets the clear win would lose that tick.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  localparam logic [5:0] OFS_INIT = 6'h00;
  localparam logic [5:0] OFS_TIME = 6'h0C;
  localparam logic [5:0] OFS_DATE = 6'h10;
  localparam logic [5:0] OFS_FMT  = 6'h14;
  localparam logic [5:0] OFS_WDAY = 6'h18;
  localparam logic [5:0] OFS_TALM = 6'h1C;
  localparam logic [5:0] OFS_DALM = 6'h20;
  localparam logic [5:0] OFS_LEAP = 6'h24;
  localparam logic [5:0] OFS_IEN  = 6'h28;
  localparam logic [5:0] OFS_ISTS = 6'h2C;

  localparam logic [31:0] UNLOCK_WORD = 32'hA5EB1357;

  // time of day, hours in the top byte
  typedef struct packed {
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sc;
  } hms_t;

  // calendar date, year offset in the top byte
  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mo;
    logic [7:0] dy;
  } ymd_t;

  localparam hms_t HMS_RESET = '{hr: 8'h00, mn: 8'h00, sc: 8'h00};
  localparam ymd_t YMD_RESET = '{yr: 8'h00, mo: 8'h01, dy: 8'h01};

  // add one to a two-digit BCD value (no wrap handling)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = v + 8'd1;
    return r;
  endfunction

  // a BCD year is a multiple of four when an even tens digit meets
  // units 0/4/8, or an odd tens digit meets units 2/6
  function automatic logic bcd_leap(input logic [7:0] yr);
    logic r;
    if (yr[4] == 1'b0) r = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else               r = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return r;
  endfunction

  // last day of a month, as BCD
  function automatic logic [7:0] bcd_last_day(input logic [7:0] mo, input logic leap);
    logic [7:0] r;
    case (mo)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_rtc_prescaler.sv
module cal_rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign sec_pulse = run && !restart && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart || !run)   cnt_q <= '0;
    else if (cnt_q == LAST)     cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cal_rtc_clock.sv
module cal_rtc_clock
  import cal_rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic        ld_hms,
  input  logic        ld_ymd,
  input  logic        ld_wd,
  input  logic [23:0] wdata,
  output hms_t        hms_q,
  output ymd_t        ymd_q,
  output logic [2:0]  wd_q,
  output hms_t        hms_nxt,
  output ymd_t        ymd_nxt,
  output logic        leap,
  output logic        midnight
);
  logic       sec_end, min_end, day_end, mon_end;
  logic [7:0] last_day;

  assign leap     = bcd_leap(ymd_q.yr);
  assign last_day = bcd_last_day(ymd_q.mo, leap);

  assign sec_end  = (hms_q.sc == 8'h59);
  assign min_end  = sec_end && (hms_q.mn == 8'h59);
  assign midnight = min_end && (hms_q.hr == 8'h23);
  assign day_end  = midnight && (ymd_q.dy == last_day);
  assign mon_end  = day_end && (ymd_q.mo == 8'h12);

  always_comb begin
    hms_nxt.sc = sec_end ? 8'h00 : bcd_inc(hms_q.sc);
    hms_nxt.mn = !sec_end ? hms_q.mn : ((hms_q.mn == 8'h59) ? 8'h00 : bcd_inc(hms_q.mn));
    hms_nxt.hr = !min_end ? hms_q.hr : ((hms_q.hr == 8'h23) ? 8'h00 : bcd_inc(hms_q.hr));
    ymd_nxt.dy = !midnight ? ymd_q.dy : (day_end ? 8'h01 : bcd_inc(ymd_q.dy));
    ymd_nxt.mo = !day_end ? ymd_q.mo : (mon_end ? 8'h01 : bcd_inc(ymd_q.mo));
    ymd_nxt.yr = !mon_end ? ymd_q.yr : ((ymd_q.yr == 8'h99) ? 8'h00 : bcd_inc(ymd_q.yr));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hms_q <= HMS_RESET;
      ymd_q <= YMD_RESET;
      wd_q  <= 3'd0;
    end else begin
      if (ld_hms)   hms_q <= hms_t'(wdata);
      else if (adv) hms_q <= hms_nxt;

      if (ld_ymd)   ymd_q <= ymd_t'(wdata);
      else if (adv) ymd_q <= ymd_nxt;

      if (ld_wd)                wd_q <= wdata[2:0];
      else if (adv && midnight) wd_q <= (wd_q >= 3'd6) ? 3'd0 : wd_q + 3'd1;
    end
  end
endmodule

// File: rtl/cal_rtc_events.sv
module cal_rtc_events
  import cal_rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  hms_t        hms_nxt,
  input  ymd_t        ymd_nxt,
  input  logic        ld_talm,
  input  logic        ld_dalm,
  input  logic        ld_ien,
  input  logic        ld_ists,
  input  logic [23:0] wdata,
  output hms_t        talm_q,
  output ymd_t        dalm_q,
  output logic [1:0]  ien_q,
  output logic [1:0]  ists_q,
  output logic        alarm_hit,
  output logic        irq
);
  logic [1:0] set_v, clr_v;

  // compare against the value the counters are about to take
  assign alarm_hit = adv && (hms_nxt == talm_q) && (ymd_nxt == dalm_q);
  assign set_v     = {adv, alarm_hit};
  assign clr_v     = ld_ists ? wdata[1:0] : 2'b00;
  assign irq       = |(ists_q & ien_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      talm_q <= HMS_RESET;
      dalm_q <= '0;
      ien_q  <= 2'b00;
      ists_q <= 2'b00;
    end else begin
      if (ld_talm) talm_q <= hms_t'(wdata);
      if (ld_dalm) dalm_q <= ymd_t'(wdata);
      if (ld_ien)  ien_q  <= wdata[1:0];
      ists_q <= set_v | (ists_q & ~clr_v);
    end
  end
endmodule

// File: rtl/cal_rtc_top.sv
module cal_rtc_top
  import cal_rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  logic       active_q;
  logic       wr_en;
  logic       ld_hms, ld_ymd, ld_wd, ld_talm, ld_dalm, ld_ien, ld_ists;
  logic       pre_restart, sec_adv;
  hms_t       hms_q, hms_nxt, talm_q;
  ymd_t       ymd_q, ymd_nxt, dalm_q;
  logic [2:0] wd_q;
  logic [1:0] ien_q, ists_q;
  logic       leap, midnight, alarm_hit;

  assign wr_en   = bus_sel && bus_wr;
  assign ld_hms  = wr_en && active_q && (bus_addr == OFS_TIME);
  assign ld_ymd  = wr_en && active_q && (bus_addr == OFS_DATE);
  assign ld_wd   = wr_en && active_q && (bus_addr == OFS_WDAY);
  assign ld_talm = wr_en && active_q && (bus_addr == OFS_TALM);
  assign ld_dalm = wr_en && active_q && (bus_addr == OFS_DALM);
  assign ld_ien  = wr_en && (bus_addr == OFS_IEN);
  assign ld_ists = wr_en && (bus_addr == OFS_ISTS);
  assign pre_restart = ld_hms || ld_ymd || ld_wd;

  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= 1'b0;
    else if (wr_en && (bus_addr == OFS_INIT) && (bus_wdata == UNLOCK_WORD)) active_q <= 1'b1;
  end

  cal_rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(active_q), .restart(pre_restart), .sec_pulse(sec_adv)
  );

  cal_rtc_clock u_clk (
    .clk(clk), .rst_n(rst_n), .adv(sec_adv),
    .ld_hms(ld_hms), .ld_ymd(ld_ymd), .ld_wd(ld_wd), .wdata(bus_wdata[23:0]),
    .hms_q(hms_q), .ymd_q(ymd_q), .wd_q(wd_q),
    .hms_nxt(hms_nxt), .ymd_nxt(ymd_nxt), .leap(leap), .midnight(midnight)
  );

  cal_rtc_events u_evt (
    .clk(clk), .rst_n(rst_n), .adv(sec_adv),
    .hms_nxt(hms_nxt), .ymd_nxt(ymd_nxt),
    .ld_talm(ld_talm), .ld_dalm(ld_dalm), .ld_ien(ld_ien), .ld_ists(ld_ists),
    .wdata(bus_wdata[23:0]),
    .talm_q(talm_q), .dalm_q(dalm_q), .ien_q(ien_q), .ists_q(ists_q),
    .alarm_hit(alarm_hit), .irq(irq)
  );

  always_comb begin
    bus_rdata = 32'd0;
    case (bus_addr)
      OFS_INIT: bus_rdata = {31'd0, active_q};
      OFS_TIME: bus_rdata = {8'd0, hms_q};
      OFS_DATE: bus_rdata = {8'd0, ymd_q};
      OFS_FMT:  bus_rdata = 32'd1;
      OFS_WDAY: bus_rdata = {29'd0, wd_q};
      OFS_TALM: bus_rdata = {8'd0, talm_q};
      OFS_DALM: bus_rdata = {8'd0, dalm_q};
      OFS_LEAP: bus_rdata = {31'd0, leap};
      OFS_IEN:  bus_rdata = {30'd0, ien_q};
      OFS_ISTS: bus_rdata = {30'd0, ists_q};
      default:  bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        active_q,
  input logic        sec_adv,
  input logic        pre_restart,
  input logic [23:0] hms_q,
  input logic [1:0]  ists_q,
  input logic [1:0]  ien_q,
  input logic        irq
);
  assert_idle_no_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !sec_adv);

  assert_idle_time_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> $stable(hms_q));

  assert_unlock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> active_q);

  assert_restart_no_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_restart |-> !sec_adv);

  assert_seconds_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_adv |=> !$stable(hms_q[7:0]));

  // holds when software only loads legal BCD times
  assert_seconds_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hms_q[7:0] <= 8'h59) && (hms_q[3:0] <= 4'd9));

  assert_alarm_on_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ists_q[0]) |-> $past(sec_adv));

  assert_tick_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_adv |=> ists_q[1]);

  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 2'b00) |-> !irq);
endmodule

bind cal_rtc_top cal_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active_q(active_q), .sec_adv(sec_adv),
  .pre_restart(pre_restart), .hms_q(hms_q), .ists_q(ists_q), .ien_q(ien_q), .irq(irq)
);

// File: tb/sim_cal_rtc_top.sv
`timescale 1ns/1ps
module sim_cal_rtc_top;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the clock, binary fields
  int m_sc, m_mn, m_hr, m_dy, m_mo, m_yr, m_wd;

  cal_rtc_top #(.TICKS_PER_SEC(P)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_of(int mo, int yr);
    if (mo == 2) return ((yr % 4) == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] pack_t(int h, int m, int s);
    return {8'h00, to_bcd(h), to_bcd(m), to_bcd(s)};
  endfunction

  function automatic logic [31:0] pack_d(int y, int mo, int d);
    return {8'h00, to_bcd(y), to_bcd(mo), to_bcd(d)};
  endfunction

  task automatic model_step();
    m_sc++;
    if (m_sc == 60) begin m_sc = 0; m_mn++; end
    if (m_mn == 60) begin m_mn = 0; m_hr++; end
    if (m_hr == 24) begin
      m_hr = 0;
      m_wd = (m_wd + 1) % 7;
      m_dy++;
      if (m_dy > days_of(m_mo, m_yr)) begin m_dy = 1; m_mo++; end
      if (m_mo == 13) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called just after a falling edge; the write lands on the next rising edge
  task automatic bus_write(logic [5:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_secs(int n);
    repeat (n * P) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_model();
    bus_write(6'h18, 32'(m_wd));
    bus_write(6'h10, pack_d(m_yr, m_mo, m_dy));
    bus_write(6'h0C, pack_t(m_hr, m_mn, m_sc));
  endtask

  task automatic compare_all(string req);
    logic [31:0] r;
    bus_read(6'h0C, r); check(req, r, pack_t(m_hr, m_mn, m_sc));
    bus_read(6'h10, r); check(req, r, pack_d(m_yr, m_mo, m_dy));
    bus_read(6'h18, r); check(req, r, 32'(m_wd));
  endtask

  task automatic run_case(string req, int y, int mo, int d, int h, int mi, int s, int wd, int n);
    m_yr = y; m_mo = mo; m_dy = d; m_hr = h; m_mn = mi; m_sc = s; m_wd = wd;
    load_model();
    wait_secs(n);
    for (int k = 0; k < n; k++) model_step();
    compare_all(req);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    bus_read(6'h0C, r); check("R1 time", r, 32'h0);
    bus_read(6'h10, r); check("R1 date", r, 32'h000101);
    bus_read(6'h18, r); check("R1 wday", r, 32'h0);
    bus_read(6'h28, r); check("R1 ien", r, 32'h0);
    bus_read(6'h2C, r); check("R1 ists", r, 32'h0);
    bus_read(6'h00, r); check("R1 init", r, 32'h0);
    bus_read(6'h14, r); check("R1 fmt", r & 32'h1, 32'h1);

    // R2 locked behaviour
    bus_write(6'h0C, 32'h00123456);
    bus_write(6'h00, 32'h12345678);
    bus_read(6'h00, r); check("R2 bad unlock", r, 32'h0);
    wait_secs(3);
    bus_read(6'h0C, r); check("R2 no count, write ignored", r, 32'h0);
    bus_read(6'h2C, r); check("R2 no tick flag", r, 32'h0);
    bus_write(6'h00, 32'hA5EB1357);
    bus_read(6'h00, r); check("R2 unlocked", r, 32'h1);

    // R12 format register
    bus_write(6'h14, 32'h0);
    bus_read(6'h14, r); check("R12 fmt fixed", r & 32'h1, 32'h1);

    // directed corners
    run_case("R3 plain", 23, 5, 17, 12, 34, 56, 3, 2);
    run_case("R4 hour carry", 23, 5, 17, 10, 59, 59, 3, 1);
    run_case("R5 30-day month, R7", 21, 4, 30, 23, 59, 59, 6, 1);
    run_case("R6 leap Feb 28", 24, 2, 28, 23, 59, 59, 2, 1);
    bus_read(6'h24, r); check("R6 leap flag 2024", r, 32'h1);
    run_case("R6 leap Feb 29", 24, 2, 29, 23, 59, 59, 3, 1);
    run_case("R6 non-leap Feb 28", 23, 2, 28, 23, 59, 59, 1, 1);
    bus_read(6'h24, r); check("R6 leap flag 2023", r, 32'h0);
    run_case("R5 century wrap", 99, 12, 31, 23, 59, 59, 5, 1);

    // random starts
    for (int i = 0; i < 20; i++) begin
      int y, mo, d;
      y  = int'($urandom_range(99, 0));
      mo = int'($urandom_range(12, 1));
      d  = int'($urandom_range(days_of(mo, y), 1));
      run_case("R3 random", y, mo, d, int'($urandom_range(23, 0)),
               int'($urandom_range(59, 0)), int'($urandom_range(59, 55)),
               int'($urandom_range(6, 0)), int'($urandom_range(3, 1)));
    end

    // R8/R9/R11 alarm two seconds ahead
    bus_write(6'h28, 32'h0);
    m_yr = 45; m_mo = 7; m_dy = 31; m_hr = 23; m_mn = 59; m_sc = 58; m_wd = 4;
    bus_write(6'h1C, pack_t(0, 0, 0));
    bus_write(6'h20, pack_d(45, 8, 1));
    bus_write(6'h2C, 32'h3);
    load_model();
    wait_secs(1);
    bus_read(6'h2C, r); check("R8 no early alarm", r, 32'h2);
    wait_secs(1);
    bus_read(6'h2C, r); check("R8 alarm match, R9 tick", r, 32'h3);
    check("R11 disabled irq", 32'(irq), 32'd0);
    bus_write(6'h28, 32'h1);
    check("R11 alarm irq", 32'(irq), 32'd1);
    bus_write(6'h2C, 32'h1);
    bus_read(6'h2C, r); check("R10 clear alarm only", r, 32'h2);
    check("R11 irq drops", 32'(irq), 32'd0);
    bus_write(6'h28, 32'h2);
    check("R11 tick irq", 32'(irq), 32'd1);

    // R10 set wins on the tick edge
    m_yr = 10; m_mo = 3; m_dy = 3; m_hr = 3; m_mn = 3; m_sc = 3; m_wd = 0;
    load_model();
    repeat (P - 1) @(negedge clk);
    bus_write(6'h2C, 32'h3);
    bus_read(6'h2C, r); check("R10 set beats clear", r, 32'h2);
    bus_write(6'h2C, 32'h2);
    bus_read(6'h2C, r); check("R10 clear", r, 32'h0);

    finish_run();
  end
endmodule